// File: doc/BRIEF.md
# SuperSpeed Link Power State Controller

This block keeps track of the link power state of one SuperSpeed port and decides when that state changes. There are four states. U0 is the working state. U1 and U2 are low-power idle states: U2 saves more power than U1 but takes longer to leave. U3 is suspend, the deepest state, and it has by far the longest wake-up time. The block counts idle cycles while in U0. When the count reaches a configured threshold, it asks the link layer to enter U1 or U2, and it moves once the link layer acknowledges the request.

The block also answers low-power requests that come from the link partner. A local busy veto, the per-state enable bits and the current state decide whether such a request is accepted or rejected. Suspend is entered only on an explicit command. When a wake or traffic event arrives in any low-power state, an exit timer starts. The timer is loaded with that state's exit latency in clock cycles, and the block reports U0 when the timer runs out.

Top module: `lps_ctrl`

## Requirements
- R1: After a synchronous reset the block reports U0. `loc_req`, `loc_req_u2`, `prt_acc` and `prt_rej` are all low.
- R2: `state_code` uses the encoding U0=0, U1=1, U2=2, U3=3. `state_oh` always has exactly one bit set, and that bit is at position `state_code`.
- R3: In U0 with `en_u1` high, `loc_req` rises with `loc_req_u2` low on the (`thr_u1`+1)-th rising edge after the last edge at which `traffic_pend` was sampled high.
- R4: When `en_u2` is high and the idle count has also reached `thr_u2`, the local request is for U2, shown by `loc_req_u2` high.
- R5: A local request is never made for a state whose enable bit was low in the cycle before.
- R6: In U0, `traffic_pend` drops any local request on the next edge and restarts the idle count from zero.
- R7: If `loc_ack` is high while `loc_req` is high in U0, with no suspend command, no accepted partner request and no pending traffic, the state becomes the requested U1 or U2 on that edge.
- R8: Every edge that samples `prt_req` high produces exactly one of `prt_acc` or `prt_rej` for one cycle after it. On accept, the state moves from U0 to U1 (`prt_req_u2`=0) or U2 (`prt_req_u2`=1) at that same edge.
- R9: A partner request is rejected, and leaves the state unchanged, when any of the following holds: `busy` is high, the requested state is disabled, the block is not in U0, or `suspend_cmd` is sampled at the same edge.
- R10: U3 is entered only from U0, on the edge after `suspend_cmd` is high. In U1, U2 and U3, `suspend_cmd` has no effect.
- R11: In U1, U2 or U3, the first `wake` or `traffic_pend` starts an exit. The state becomes U0 exactly U1_EXIT, U2_EXIT or U3_EXIT edges later, according to the state being left. Further events during the exit change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_u1 | input | 1 | U1 entry enabled |
| en_u2 | input | 1 | U2 entry enabled |
| thr_u1 | input | CNT_W | Idle cycles before a U1 request |
| thr_u2 | input | CNT_W | Idle cycles before a U2 request |
| traffic_pend | input | 1 | Traffic is pending |
| busy | input | 1 | Local veto on partner requests |
| loc_ack | input | 1 | Link layer acknowledges the local request |
| prt_req | input | 1 | Partner requests low-power entry |
| prt_req_u2 | input | 1 | Partner request type: 0 = U1, 1 = U2 |
| suspend_cmd | input | 1 | Suspend command |
| wake | input | 1 | Wake event |
| state_code | output | 2 | Current state, encoded |
| state_oh | output | 4 | Current state, one-hot |
| loc_req | output | 1 | Local entry request |
| loc_req_u2 | output | 1 | Local request type: 1 = U2 |
| prt_acc | output | 1 | Partner request accepted |
| prt_rej | output | 1 | Partner request rejected |

## Verification
The hardest case to reach is an event that arrives in the middle of an exit: a second wake or traffic pulse must not reload the exit timer. Reaching it takes a full round trip. The stimulus first lets the idle counter reach the U2 threshold, then acknowledges the local request, and only then sends a traffic pulse followed a few cycles later by a wake pulse, while the exit timer is still counting down. The stimulus also forces a partner request and a suspend command into the same cycle, and issues partner requests while the block sits in U1 and U3. A behavioural model in the bench tracks every output on every clock through all of these cases.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    LS_U0 = 2'd0,
    LS_U1 = 2'd1,
    LS_U2 = 2'd2,
    LS_U3 = 2'd3
  } lstate_t;
endpackage

// File: rtl/lps_idle_mon.sv
module lps_idle_mon #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en_u1,
  input  logic             en_u2,
  input  logic [CNT_W-1:0] thr_u1,
  input  logic [CNT_W-1:0] thr_u2,
  output logic             want_u1,
  output logic             want_u2
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  // saturating count of quiet cycles
  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (cnt != CMAX) cnt <= cnt + 1'b1;
  end

  always_comb begin
    want_u1 = en_u1 && (cnt >= thr_u1);
    want_u2 = en_u2 && (cnt >= thr_u2);
  end
endmodule

// File: rtl/lps_exit_timer.sv
module lps_exit_timer #(
  parameter int T_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [T_W-1:0] load_val,
  output logic           active,
  output logic           expire
);
  logic [T_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) tmr <= '0;
    else if (load) tmr <= load_val;
    else if (tmr != '0) tmr <= tmr - 1'b1;
  end

  always_comb begin
    active = (tmr != '0);
    expire = (tmr == T_W'(1));
  end

  // R11: a loaded timer is counting on the next cycle
  p_load_runs_r11: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> active);
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int U1_EXIT = 6,
  parameter int U2_EXIT = 20,
  parameter int U3_EXIT = 300
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_u1,
  input  logic             en_u2,
  input  logic [CNT_W-1:0] thr_u1,
  input  logic [CNT_W-1:0] thr_u2,
  input  logic             traffic_pend,
  input  logic             busy,
  input  logic             loc_ack,
  input  logic             prt_req,
  input  logic             prt_req_u2,
  input  logic             suspend_cmd,
  input  logic             wake,
  output logic [1:0]       state_code,
  output logic [3:0]       state_oh,
  output logic             loc_req,
  output logic             loc_req_u2,
  output logic             prt_acc,
  output logic             prt_rej
);
  localparam int LAT_A   = (U1_EXIT > U2_EXIT) ? U1_EXIT : U2_EXIT;
  localparam int LAT_MAX = (LAT_A > U3_EXIT) ? LAT_A : U3_EXIT;
  localparam int T_W     = $clog2(LAT_MAX + 1);

  lstate_t st_q;
  logic    lreq_q, lu2_q, acc_q, rej_q;
  logic    want_u1, want_u2;
  logic    idle_clr, prt_ok;
  logic    tmr_load, tmr_active, tmr_expire;
  logic [T_W-1:0] lat_sel;

  assign idle_clr = (st_q != LS_U0) || traffic_pend;

  lps_idle_mon #(.CNT_W(CNT_W)) u_idle (
    .clk(clk), .rst(rst), .clear(idle_clr),
    .en_u1(en_u1), .en_u2(en_u2),
    .thr_u1(thr_u1), .thr_u2(thr_u2),
    .want_u1(want_u1), .want_u2(want_u2)
  );

  always_comb begin
    case (st_q)
      LS_U1:   lat_sel = T_W'(U1_EXIT);
      LS_U2:   lat_sel = T_W'(U2_EXIT);
      default: lat_sel = T_W'(U3_EXIT);
    endcase
  end

  assign tmr_load = (st_q != LS_U0) && !tmr_active && (traffic_pend || wake);

  lps_exit_timer #(.T_W(T_W)) u_exit (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(lat_sel),
    .active(tmr_active), .expire(tmr_expire)
  );

  // partner entry accepted only from U0, enabled, not vetoed, no suspend
  assign prt_ok = prt_req && (st_q == LS_U0) && !suspend_cmd && !busy &&
                  (prt_req_u2 ? en_u2 : en_u1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LS_U0;
      lreq_q <= 1'b0;
      lu2_q  <= 1'b0;
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
    end else begin
      acc_q <= prt_ok;
      rej_q <= prt_req && !prt_ok;
      if (st_q == LS_U0) begin
        if (suspend_cmd) begin
          st_q   <= LS_U3;
          lreq_q <= 1'b0;
          lu2_q  <= 1'b0;
        end else if (prt_ok) begin
          st_q   <= prt_req_u2 ? LS_U2 : LS_U1;
          lreq_q <= 1'b0;
          lu2_q  <= 1'b0;
        end else if (traffic_pend) begin
          lreq_q <= 1'b0;
          lu2_q  <= 1'b0;
        end else if (lreq_q && loc_ack) begin
          st_q   <= lu2_q ? LS_U2 : LS_U1;
          lreq_q <= 1'b0;
          lu2_q  <= 1'b0;
        end else begin
          lreq_q <= want_u1 || want_u2;
          lu2_q  <= want_u2;
        end
      end else begin
        lreq_q <= 1'b0;
        lu2_q  <= 1'b0;
        if (tmr_expire) st_q <= LS_U0;
      end
    end
  end

  always_comb begin
    state_code = st_q;
    state_oh   = 4'b0001 << st_q;
    loc_req    = lreq_q;
    loc_req_u2 = lu2_q;
    prt_acc    = acc_q;
    prt_rej    = rej_q;
  end

  // R2: one-hot view agrees with the encoded state
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(state_oh) == 1) && state_oh[state_code]);

  // R8: one reply per partner request
  p_reply_r8: assert property (@(posedge clk) disable iff (rst)
    prt_req |=> (prt_acc != prt_rej));

  // R9: a vetoed request is refused
  p_busy_rej_r9: assert property (@(posedge clk) disable iff (rst)
    (prt_req && busy) |=> prt_rej);

  // R10: suspend is entered only on command from U0
  p_u3_cmd_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == LS_U3 && $past(st_q) != LS_U3) |-> ($past(suspend_cmd) && $past(st_q) == LS_U0));

  // R5: requests only for states enabled one cycle earlier
  p_lreq_u2_en_r5: assert property (@(posedge clk) disable iff (rst)
    (loc_req && loc_req_u2) |-> $past(en_u2));
  p_lreq_u1_en_r5: assert property (@(posedge clk) disable iff (rst)
    (loc_req && !loc_req_u2) |-> $past(en_u1));

  // R6: pending traffic withdraws a local request
  p_trf_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == LS_U0 && traffic_pend) |=> !loc_req);
endmodule

// File: tb/lps_ctrl_test.sv
module lps_ctrl_test;
  localparam int CW = 12;
  localparam int L1 = 6, L2 = 20, L3 = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_u1 = 0, en_u2 = 0, traffic_pend = 0, busy = 0, loc_ack = 0;
  logic prt_req = 0, prt_req_u2 = 0, suspend_cmd = 0, wake = 0;
  logic [CW-1:0] thr_u1 = 12'd10, thr_u2 = 12'd25;
  logic [1:0] state_code;
  logic [3:0] state_oh;
  logic loc_req, loc_req_u2, prt_acc, prt_rej;

  always #4 clk = ~clk;

  lps_ctrl #(.CNT_W(CW), .U1_EXIT(L1), .U2_EXIT(L2), .U3_EXIT(L3)) uut (
    .clk(clk), .rst(rst), .en_u1(en_u1), .en_u2(en_u2),
    .thr_u1(thr_u1), .thr_u2(thr_u2), .traffic_pend(traffic_pend),
    .busy(busy), .loc_ack(loc_ack), .prt_req(prt_req), .prt_req_u2(prt_req_u2),
    .suspend_cmd(suspend_cmd), .wake(wake),
    .state_code(state_code), .state_oh(state_oh), .loc_req(loc_req),
    .loc_req_u2(loc_req_u2), .prt_acc(prt_acc), .prt_rej(prt_rej)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit started = 0;

  // behavioural reference: edge numbers instead of counters
  int edge_no = 0, quiet_from = 0, exit_at = -1, m_st = 0;
  bit m_lr = 0, m_lu2 = 0, m_acc = 0, m_rej = 0;

  function automatic int exit_len(int s);
    return (s == 1) ? L1 : (s == 2) ? L2 : L3;
  endfunction

  always @(posedge clk) begin
    int idle, prev;
    bit ok, w1, w2;
    edge_no++;
    if (rst) begin
      m_st = 0; m_lr = 0; m_lu2 = 0; m_acc = 0; m_rej = 0;
      quiet_from = edge_no; exit_at = -1;
    end else begin
      prev = m_st;
      idle = edge_no - quiet_from - 1;
      if (idle > 4095) idle = 4095;
      w1 = en_u1 && idle >= int'(thr_u1);
      w2 = en_u2 && idle >= int'(thr_u2);
      ok = prt_req && m_st == 0 && !suspend_cmd && !busy && (prt_req_u2 ? en_u2 : en_u1);
      m_acc = ok;
      m_rej = prt_req && !ok;
      if (m_st == 0) begin
        if (suspend_cmd) begin m_st = 3; m_lr = 0; m_lu2 = 0; end
        else if (ok) begin m_st = prt_req_u2 ? 2 : 1; m_lr = 0; m_lu2 = 0; end
        else if (traffic_pend) begin m_lr = 0; m_lu2 = 0; end
        else if (m_lr && loc_ack) begin m_st = m_lu2 ? 2 : 1; m_lr = 0; m_lu2 = 0; end
        else begin m_lr = w1 || w2; m_lu2 = w2; end
      end else begin
        m_lr = 0; m_lu2 = 0;
        if (exit_at == edge_no) begin m_st = 0; exit_at = -1; end
        else if (exit_at < 0 && (traffic_pend || wake)) exit_at = edge_no + exit_len(m_st);
      end
      if (prev != 0 || traffic_pend) quiet_from = edge_no;
    end
    started = 1;
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(cur_req, "state_code", state_code, m_st);
      chk("R2", "state_oh", state_oh, 1 << m_st);
      chk(cur_req, "loc_req", loc_req, m_lr);
      chk(cur_req, "loc_req_u2", loc_req_u2, m_lu2);
      chk(cur_req, "prt_acc", prt_acc, m_acc);
      chk(cur_req, "prt_rej", prt_rej, m_rej);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_trf();
    traffic_pend = 1; step(1); traffic_pend = 0;
  endtask

  task automatic pulse_wake();
    wake = 1; step(1); wake = 0;
  endtask

  task automatic ack_when_req();
    for (int i = 0; i < 200 && !loc_req; i++) step(1);
    loc_ack = 1; step(1); loc_ack = 0;
  endtask

  task automatic partner(bit u2);
    prt_req = 1; prt_req_u2 = u2; step(1); prt_req = 0; prt_req_u2 = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(3);
    rst = 0;
    step(1);
    // R1: reset state
    chk("R1", "state after reset", state_code, 0);
    chk("R1", "loc_req after reset", loc_req, 0);
    chk("R1", "replies after reset", prt_acc | prt_rej, 0);

    cur_req = "R3"; en_u1 = 1; step(20);
    cur_req = "R6"; pulse_trf(); step(5);
    cur_req = "R7"; ack_when_req(); step(3);
    cur_req = "R11"; pulse_wake(); step(10);

    cur_req = "R4"; en_u2 = 1; step(30);
    cur_req = "R7"; ack_when_req(); step(2);
    cur_req = "R11"; pulse_trf(); step(5); pulse_wake(); step(25);

    cur_req = "R5"; en_u1 = 0; en_u2 = 0; step(40);

    cur_req = "R9"; en_u1 = 1; busy = 1; partner(0); busy = 0; step(2);
    partner(1); step(2);
    cur_req = "R8"; partner(0); step(2);
    cur_req = "R10"; suspend_cmd = 1; step(1); suspend_cmd = 0; step(2);
    cur_req = "R9"; partner(0); step(2);
    cur_req = "R11"; pulse_wake(); step(10);

    cur_req = "R10"; suspend_cmd = 1; step(1); suspend_cmd = 0; step(3);
    suspend_cmd = 1; step(1); suspend_cmd = 0;
    cur_req = "R9"; partner(0); step(2);
    cur_req = "R11"; pulse_wake(); step(L3 + 5);

    cur_req = "R9"; suspend_cmd = 1; prt_req = 1; step(1);
    suspend_cmd = 0; prt_req = 0; step(3);
    cur_req = "R11"; pulse_trf(); step(L3 + 5);

    finish_run();
  end
endmodule